// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

The block keeps a running history of digitized channel samples in a circular delay memory and, when a level-1 accept arrives, copies a window of that history into one of eight event slots. The window starts at the sample that arrived a programmable number of valid samples before the accept, so the trigger latency is absorbed. Its length is a programmable number of samples. Each captured event is tagged with the beam-crossing counter and the level-1 event number present at the accept.

Completed events leave through a small output FIFO as 34-bit words: a header word, then one word per sample. Words move into the FIFO only while the readout token is held, and the FIFO is drained on every cycle in which it is not empty. After the last word of an event is written, the token is passed on with a one-cycle pulse. A daisy chain of boards can share one readout path in this way.

Top module: `trig_capture`

## Requirements
- R1: After reset, `out_valid`, `token_out` and `overflow` are 0.
- R2: The first sample stored for an event is the valid sample that arrived `delay` valid samples before the first valid sample at or after the accept cycle. The rest follow in arrival order. A delay of 0 stores the current input sample.
- R3: Only cycles with `samp_valid` high advance the delay memory and the capture. Gaps in the valid strobe do not change the stored values.
- R4: The per-event sample count is `cfg_nsamp` clamped to the range 1 to 32: 0 gives 1, and values above 32 give 32.
- R5: The lookback delay is `cfg_delay` clamped to the delay memory depth minus one (63 by default).
- R6: Output word bit 33 is the first flag and bit 32 is the last flag. The header word has the first flag set, `bc_count` in bits 31:16 and `evt_num` in bits 15:0. Sample words carry the sample zero-extended in bits 31:0. Only the final sample word has the last flag set.
- R7: A word is written into the output FIFO only in a cycle where `token_in` is high, at most one per cycle. It appears on `out_word` with `out_valid` high in the next cycle. No word appears while the token is low.
- R8: `token_out` pulses high for exactly one cycle, in the cycle where the last word of an event is shown on the output.
- R9: The buffer holds up to 8 unread events. An accept that arrives while 8 are held is dropped and sets `overflow`, which stays set until reset. Held events are never overwritten.
- R10: An accept that arrives while a capture is still in progress is ignored and does not set `overflow`.
- R11: Events are read out in the order of their accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Sample strobe |
| samp_data | input | 16 | Channel sample |
| l1_accept | input | 1 | Level-1 accept strobe |
| bc_count | input | 16 | Beam-crossing counter |
| evt_num | input | 16 | Level-1 event number |
| token_in | input | 1 | Readout token from the previous board |
| cfg_delay | input | 7 | Lookback delay in valid samples |
| cfg_nsamp | input | 6 | Samples per event |
| out_word | output | 34 | First flag, last flag, 32 data bits |
| out_valid | output | 1 | Output word present |
| token_out | output | 1 | Token pass pulse |
| overflow | output | 1 | Sticky event-drop flag |

## Verification
The bench feeds a ramp so that every stored sample shows exactly which lookback it came from. An off-by-one in the delay subtraction, or a zero-delay path that reads stale memory, therefore shows up as a wrong sample value. Gapped valid strobes catch a write pointer that runs on every cycle. Zero and oversized sample counts, and an oversized delay, catch missing clamps. A second accept during a long capture catches a design that restarts or double-books a slot. Nine accepts with the token held low catch a design that overwrites an unread slot, or fails to raise and hold the drop flag. A token toggling every cycle catches a design that writes words without the token or loses its place within an event.

// File: rtl/tcb_pkg.sv
// Shared types for the triggered sample capture buffer.
// Assumes a 32-bit data field in every output word.
package tcb_pkg;
    localparam int WORD_DATA_W = 32;

    typedef struct packed {
        logic                   first;
        logic                   last;
        logic [WORD_DATA_W-1:0] data;
    } out_word_t;
endpackage

// File: rtl/tcb_delay_line.sv
// Circular history of valid samples with a lookback read port.
// Assumes DEPTH is a power of two and that delay < DEPTH. A delay of 0
// returns the sample being written in the same cycle.
module tcb_delay_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     delay,
    output logic [DATA_W-1:0] look_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rd_addr;

    // Write pointer advances once per valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) wptr <= '0;
        else if (wr_en) wptr <= wptr + 1'b1;
    end

    // Store each valid sample at the current pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    // Lookback address wraps modulo the depth; zero delay bypasses memory.
    always_comb begin
        rd_addr   = wptr - delay;
        look_data = (delay == '0) ? wr_data : mem[rd_addr];
    end
endmodule

// File: rtl/tcb_event_store.sv
// Eight-slot event buffer. On an accepted trigger it reserves a slot, records
// the header and the length, and then stores one lookback sample per valid
// cycle until the length is reached. A slot is freed by the readout side.
// Assumes SLOT_N and SAMP_MAX are powers of two and that nsamp is 1..SAMP_MAX.
module tcb_event_store #(
    parameter int DATA_W   = 16,
    parameter int HDR_W    = 32,
    parameter int SLOT_N   = 8,
    parameter int SAMP_MAX = 32,
    localparam int SLOT_AW = $clog2(SLOT_N),
    localparam int SAMP_AW = $clog2(SAMP_MAX),
    localparam int CNT_W   = SLOT_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic               samp_valid,
    input  logic [DATA_W-1:0]  look_data,
    input  logic [SAMP_AW:0]   nsamp,
    input  logic [HDR_W-1:0]   hdr_in,
    input  logic [SAMP_AW-1:0] rd_idx,
    input  logic               release_slot,
    output logic               ready,
    output logic [HDR_W-1:0]   rd_hdr,
    output logic [SAMP_AW:0]   rd_len,
    output logic [DATA_W-1:0]  rd_data,
    output logic               overflow
);
    logic [DATA_W-1:0]  mem     [SLOT_N*SAMP_MAX];
    logic [HDR_W-1:0]   hdr_mem [SLOT_N];
    logic [SAMP_AW:0]   len_mem [SLOT_N];
    logic [SLOT_AW-1:0] wslot, rslot;
    logic [CNT_W-1:0]   used;
    logic               busy;
    logic [SAMP_AW:0]   cap_idx, cap_len, cur_idx, cur_len;
    logic               trig_ok, trig_full, cap_act, cap_wr, cap_last;

    // Accept decision and current capture position.
    always_comb begin
        trig_ok   = trig && !busy && (used != CNT_W'(SLOT_N));
        trig_full = trig && !busy && (used == CNT_W'(SLOT_N));
        cap_act   = trig_ok || busy;
        cur_idx   = busy ? cap_idx : '0;
        cur_len   = busy ? cap_len : nsamp;
        cap_wr    = cap_act && samp_valid;
        cap_last  = cap_wr && ((cur_idx + 1'b1) == cur_len);
    end

    // Sample, header and length storage.
    always_ff @(posedge clk) begin
        if (cap_wr) mem[{wslot, cur_idx[SAMP_AW-1:0]}] <= look_data;
        if (trig_ok) begin
            hdr_mem[wslot] <= hdr_in;
            len_mem[wslot] <= nsamp;
        end
    end

    // Capture sequencing, slot bookkeeping and the sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cap_idx  <= '0;
            cap_len  <= '0;
            wslot    <= '0;
            rslot    <= '0;
            used     <= '0;
            overflow <= 1'b0;
        end else begin
            if (cap_act) busy <= !cap_last;
            if (cap_last)    cap_idx <= '0;
            else if (cap_wr) cap_idx <= cur_idx + 1'b1;
            else if (trig_ok) cap_idx <= '0;
            if (trig_ok) cap_len <= nsamp;
            if (cap_last) wslot <= wslot + 1'b1;
            if (release_slot) rslot <= rslot + 1'b1;
            used <= used + CNT_W'(trig_ok) - CNT_W'(release_slot);
            if (trig_full) overflow <= 1'b1;
        end
    end

    // Read side: a slot is readable once its capture has finished.
    always_comb begin
        ready   = used > CNT_W'(busy);
        rd_hdr  = hdr_mem[rslot];
        rd_len  = len_mem[rslot];
        rd_data = mem[{rslot, rd_idx}];
    end
endmodule

// File: rtl/tcb_readout.sv
// Token-gated readout sequencer. While the token is held and a complete
// event is waiting, it writes one word per cycle: the header, then each
// sample. After the last word it frees the slot and pulses the token onward.
// Assumes the FIFO reports full correctly; it never writes when full.
module tcb_readout #(
    parameter int DATA_W  = 16,
    parameter int SAMP_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                token_in,
    input  logic                ready,
    input  logic [31:0]         rd_hdr,
    input  logic [SAMP_AW:0]    rd_len,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                fifo_full,
    output logic [SAMP_AW-1:0]  rd_idx,
    output logic                release_slot,
    output logic                wr_en,
    output tcb_pkg::out_word_t  wr_word,
    output logic                token_out
);
    logic [SAMP_AW:0] pos;
    logic             is_hdr, is_last;

    // Build the word for the current position.
    always_comb begin
        is_hdr       = (pos == '0);
        is_last      = !is_hdr && (pos == rd_len);
        wr_en        = token_in && ready && !fifo_full;
        rd_idx       = SAMP_AW'(pos - 1'b1);
        release_slot = wr_en && is_last;
        wr_word.first = is_hdr;
        wr_word.last  = is_last;
        wr_word.data  = is_hdr ? rd_hdr : 32'(rd_data);
    end

    // Position within the event and the token pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            token_out <= 1'b0;
        end else begin
            if (release_slot) pos <= '0;
            else if (wr_en)   pos <= pos + 1'b1;
            token_out <= release_slot;
        end
    end
endmodule

// File: rtl/tcb_out_fifo.sv
// Output FIFO that presents its head word and pops it on every cycle in
// which it is not empty. Assumes DEPTH is a power of two.
module tcb_out_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wr_ok;

    // Status and head word.
    always_comb begin
        full      = (cnt == (AW+1)'(DEPTH));
        out_valid = (cnt != '0);
        out_data  = mem[rp];
        wr_ok     = wr_en && !full;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    // Pointers and occupancy; the head is consumed whenever present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok)     wp <= wp + 1'b1;
            if (out_valid) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(out_valid);
        end
    end
endmodule

// File: rtl/trig_capture.sv
// Top of the triggered sample capture buffer. Clamps the settings, keeps
// the delay history, captures triggered windows into event slots and reads
// them out through the token-gated output FIFO.
// Assumes DLY_DEPTH and FIFO_DEPTH are powers of two.
module trig_capture #(
    parameter int DATA_W     = 16,
    parameter int HDR_W      = 16,
    parameter int DLY_DEPTH  = 64,
    parameter int FIFO_DEPTH = 4,
    localparam int DLY_AW    = $clog2(DLY_DEPTH),
    localparam int SLOT_N    = 8,
    localparam int SAMP_MAX  = 32,
    localparam int SAMP_AW   = $clog2(SAMP_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic [DATA_W-1:0]   samp_data,
    input  logic                l1_accept,
    input  logic [HDR_W-1:0]    bc_count,
    input  logic [HDR_W-1:0]    evt_num,
    input  logic                token_in,
    input  logic [DLY_AW:0]     cfg_delay,
    input  logic [SAMP_AW:0]    cfg_nsamp,
    output logic [33:0]         out_word,
    output logic                out_valid,
    output logic                token_out,
    output logic                overflow
);
    logic [DLY_AW-1:0]  dly_eff;
    logic [SAMP_AW:0]   nsamp_eff;
    logic [DATA_W-1:0]  look_data, rd_data;
    logic [2*HDR_W-1:0] rd_hdr;
    logic [SAMP_AW:0]   rd_len;
    logic [SAMP_AW-1:0] rd_idx;
    logic               ready, release_slot, wr_en, fifo_full;
    tcb_pkg::out_word_t wr_word;

    // Clamp the settings into their legal ranges.
    always_comb begin
        dly_eff = (cfg_delay > (DLY_AW+1)'(DLY_DEPTH-1)) ? DLY_AW'(DLY_DEPTH-1)
                                                        : cfg_delay[DLY_AW-1:0];
        if (cfg_nsamp == '0)                           nsamp_eff = (SAMP_AW+1)'(1);
        else if (cfg_nsamp > (SAMP_AW+1)'(SAMP_MAX))   nsamp_eff = (SAMP_AW+1)'(SAMP_MAX);
        else                                           nsamp_eff = cfg_nsamp;
    end

    tcb_delay_line #(.DATA_W(DATA_W), .DEPTH(DLY_DEPTH)) u_dly (
        .clk(clk), .rst_n(rst_n), .wr_en(samp_valid), .wr_data(samp_data),
        .delay(dly_eff), .look_data(look_data)
    );

    tcb_event_store #(.DATA_W(DATA_W), .HDR_W(2*HDR_W), .SLOT_N(SLOT_N),
                      .SAMP_MAX(SAMP_MAX)) u_evt (
        .clk(clk), .rst_n(rst_n), .trig(l1_accept), .samp_valid(samp_valid),
        .look_data(look_data), .nsamp(nsamp_eff), .hdr_in({bc_count, evt_num}),
        .rd_idx(rd_idx), .release_slot(release_slot), .ready(ready),
        .rd_hdr(rd_hdr), .rd_len(rd_len), .rd_data(rd_data), .overflow(overflow)
    );

    tcb_readout #(.DATA_W(DATA_W), .SAMP_AW(SAMP_AW)) u_ro (
        .clk(clk), .rst_n(rst_n), .token_in(token_in), .ready(ready),
        .rd_hdr(rd_hdr), .rd_len(rd_len), .rd_data(rd_data), .fifo_full(fifo_full),
        .rd_idx(rd_idx), .release_slot(release_slot), .wr_en(wr_en),
        .wr_word(wr_word), .token_out(token_out)
    );

    tcb_out_fifo #(.W(34), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_word),
        .full(fifo_full), .out_valid(out_valid), .out_data(out_word)
    );
endmodule

// File: rtl/tcb_checker.sv
// Port-level properties of the capture buffer, bound to the top module.
module tcb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        token_in,
    input logic [33:0] out_word,
    input logic        out_valid,
    input logic        token_out,
    input logic        overflow
);
    AST_TOKOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);                                   // R8
    AST_TOKOUT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> (out_valid && out_word[32]));                  // R8
    AST_FIRST_LAST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_word[33] && out_word[32]));              // R6
    AST_OUT_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> $past(token_in));       // R7
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                      // R9
endmodule

bind trig_capture tcb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .out_word(out_word),
    .out_valid(out_valid), .token_out(token_out), .overflow(overflow)
);

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_valid = 1'b0;
    logic [15:0] samp_data = '0;
    logic        l1_accept = 1'b0;
    logic [15:0] bc_count = '0;
    logic [15:0] evt_num = '0;
    logic        token_in = 1'b0;
    logic [6:0]  cfg_delay = '0;
    logic [5:0]  cfg_nsamp = 6'd1;
    logic [33:0] out_word;
    logic        out_valid, token_out, overflow;

    trig_capture u_trig_capture (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .l1_accept(l1_accept), .bc_count(bc_count), .evt_num(evt_num),
        .token_in(token_in), .cfg_delay(cfg_delay), .cfg_nsamp(cfg_nsamp),
        .out_word(out_word), .out_valid(out_valid), .token_out(token_out),
        .overflow(overflow)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int sc = 0;
    int cyc = 0;
    int evn = 0;
    bit gap_mode = 0;
    bit gap_phase = 0;
    bit tok = 0;
    bit tok_mode = 0;
    bit tok_phase = 0;
    bit done = 0;

    logic [33:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge.
    task automatic cycle(input bit trig);
        bit v;
        @(negedge clk);
        v = gap_mode ? gap_phase : 1'b1;
        gap_phase = ~gap_phase;
        samp_valid = v;
        samp_data  = 16'(sc);
        l1_accept  = trig;
        bc_count   = 16'(cyc);
        evt_num    = 16'(evn);
        token_in   = tok_mode ? tok_phase : tok;
        tok_phase  = ~tok_phase;
        cyc++;
        if (trig) evn++;
        if (v) sc++;
    endtask

    // Push the expected words of an accepted event, then drive its trigger.
    task automatic trig_event(input int d, input int n, input string tag);
        exp_q.push_back({1'b1, 1'b0, 16'(cyc), 16'(evn)});
        tag_q.push_back("R6");
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, (i == n-1), 16'h0, 16'(sc - d + i)});
            tag_q.push_back(tag);
        end
        cycle(1);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cycle(0);
    endtask

    task automatic drain;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) cycle(0);
        idle(4);
        chk(exp_q.size() == 0, "R11", "expected words left over", exp_q.size(), 0);
    endtask

    // Monitor: compare every output word against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R7", "unexpected output word", out_word, 0);
                    end else begin
                        logic [33:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(out_word == e, t, "output word", out_word, e);
                    end
                end
                if (token_out || (out_valid && out_word[32]))
                    chk(token_out == (out_valid && out_word[32]), "R8",
                        "token_out vs last word", token_out, out_valid && out_word[32]);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(token_out == 0, "R1", "token_out after reset", token_out, 0);
        chk(overflow == 0,  "R1", "overflow after reset", overflow, 0);

        // Fill the delay history.
        tok = 1;
        idle(80);

        // R2 basic lookback.
        cfg_delay = 7'd5; cfg_nsamp = 6'd4;
        trig_event(5, 4, "R2");
        drain();

        // R2 zero delay, single sample.
        cfg_delay = 7'd0; cfg_nsamp = 6'd1;
        trig_event(0, 1, "R2");
        drain();

        // R4 clamp low and high.
        cfg_delay = 7'd2; cfg_nsamp = 6'd0;
        trig_event(2, 1, "R4");
        drain();
        cfg_nsamp = 6'd40;
        trig_event(2, 32, "R4");
        drain();

        // R5 delay clamp to 63.
        cfg_delay = 7'd100; cfg_nsamp = 6'd3;
        trig_event(63, 3, "R5");
        drain();

        // R3 gapped valid strobe, trigger on both phases.
        gap_mode = 1;
        cfg_delay = 7'd3; cfg_nsamp = 6'd6;
        trig_event(3, 6, "R3");
        idle(20);
        cycle(0);
        trig_event(3, 6, "R3");
        drain();
        gap_mode = 0;

        // R7 token toggling every cycle.
        tok_mode = 1;
        cfg_delay = 7'd4; cfg_nsamp = 6'd5;
        trig_event(4, 5, "R7");
        drain();
        tok_mode = 0;

        // R10 second accept during a long capture is ignored.
        cfg_delay = 7'd2; cfg_nsamp = 6'd20;
        trig_event(2, 20, "R10");
        idle(3);
        cycle(1);
        idle(2);
        chk(overflow == 0, "R10", "overflow after accept during capture", overflow, 0);
        drain();

        // R9 fill all slots with the token low, then one more accept.
        tok = 0;
        cfg_delay = 7'd1; cfg_nsamp = 6'd2;
        for (int k = 0; k < 8; k++) begin
            trig_event(1, 2, "R11");
            idle(4);
        end
        chk(out_valid == 0, "R7", "output while token low", out_valid, 0);
        chk(overflow == 0, "R9", "overflow with 8 held", overflow, 0);
        cycle(1);
        cycle(0);
        chk(overflow == 1, "R9", "overflow after ninth accept", overflow, 1);
        idle(3);
        tok = 1;
        drain();
        chk(overflow == 1, "R9", "overflow sticky", overflow, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule